// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is a parallel-in, serial-out shift register with eight stages by default. The stages are named A to H, and stage H is the serial end. A level-sensitive load control copies an 8-bit parallel word into every stage. When the load control is released, a clocking edge moves the contents one stage toward H. Stage A takes the serial input on each such move.

The clocking edge comes from two pin inputs with the same function. The effective clock is their OR, so a rising edge on either input while the other is low shifts the register. Raising one input while the other is already high does nothing. Stage H drives a true serial output and a separately registered complemented output.

All pin inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer. Edges are then detected on the sampled effective clock, so the whole block runs in the system clock domain.

Top module: `gated_shift_reg`

## Requirements
- R1: A synchronous active-high reset clears all stages to 0, so `qOut` is 0 and `qOutN` is 1.
- R2: While `loadN` is low, every stage takes its own bit of `parIn`. Bit 7 goes to stage H, which drives `qOut`, and bit 0 goes to stage A.
- R3: While `loadN` is low, `clkIn`, `clkGate` and `serIn` have no effect. The register follows `parIn` whatever their levels or edges.
- R4: With `loadN` high and `clkGate` low, a 0-to-1 change of `clkIn` shifts once. `serIn` enters stage A and each stage takes the old value of the stage before it, toward H.
- R5: With `loadN` high and `clkIn` low, a 0-to-1 change of `clkGate` shifts once, in the same way as R4.
- R6: A 0-to-1 change of one clock input while the other is already high causes no shift. A clock input falling causes no shift either.
- R7: With no clocking edge and `loadN` high, the register holds, whatever `serIn` does.
- R8: `qOutN` is always the logical inverse of `qOut`.
- R9: A rising effective-clock edge that happens while `loadN` is low is discarded. After `loadN` returns high, the register holds the last loaded word until the next new edge.
- R10: A change on any pin input is visible at `qOut` after exactly the third rising system-clock edge that follows it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| clkIn | input | 1 | Shift clock pin input (asynchronous) |
| clkGate | input | 1 | Second shift clock pin input, interchangeable with clkIn |
| loadN | input | 1 | Parallel load control, active low (level) |
| serIn | input | 1 | Serial data into stage A |
| parIn | input | WIDTH | Parallel data, bit 0 to stage A, bit WIDTH-1 to stage H |
| qOut | output | 1 | Stage H, true serial output |
| qOutN | output | 1 | Complement of stage H |

## Verification
A pin change driven before rising edge t is caught by the first synchronizer flop at t and by the second at t+1. The register updates at t+2, so the output is due at the third rising edge. The bench holds a behavioural model that delays the pin history by the same three edges and compares `qOut` and `qOutN` at every falling edge. Directed checks wait three falling edges after each stimulus before sampling. One latency check samples after two falling edges to confirm the old value is still present, then after the third to confirm the new one.

// File: rtl/psr_pkg.sv
package psr_pkg;

  // Strobes from the control unit to the datapath, valid for one system cycle.
  typedef struct packed {
    logic loadEn;   // level load of the parallel word
    logic shiftEn;  // one-stage move toward the serial end
    logic serBit;   // synchronized serial input bit
  } psrStrobe_t;

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_flop
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe[s] <= RESET_VAL;
      end else if (s == 0) begin
        pipe[s] <= din;
      end else begin
        pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clkSync,
  input  logic       gateSync,
  input  logic       loadNSync,
  input  logic       serSync,
  output psrStrobe_t strobe
);

  logic effClk;
  logic effPrev;

  // Either clock input can produce the clocking edge.
  assign effClk = clkSync | gateSync;

  // The edge memory keeps tracking during a load, so an edge seen then is consumed.
  always_ff @(posedge clk) begin
    if (rst) effPrev <= 1'b0;
    else     effPrev <= effClk;
  end

  always_comb begin
    strobe.loadEn  = ~loadNSync;
    strobe.shiftEn = loadNSync & effClk & ~effPrev;
    strobe.serBit  = serSync;
  end

  // R6: one clocking edge gives at most one shift.
  assert_single_shift_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.shiftEn |=> !strobe.shiftEn);

  // R6: a clock input held high blocks edges on the other.
  assert_clk_high_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (clkSync && $past(clkSync)) |-> !strobe.shiftEn);

  assert_gate_high_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (gateSync && $past(gateSync)) |-> !strobe.shiftEn);

endmodule

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  psrStrobe_t       strobe,
  input  logic [WIDTH-1:0] parData,
  output logic             qOut,
  output logic             qOutN
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stages;
  logic [WIDTH-1:0] nextStages;
  logic             lastN;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic shiftSrc;
    if (i == 0) begin : g_head
      assign shiftSrc = strobe.serBit;
    end else begin : g_body
      assign shiftSrc = stages[i-1];
    end
    // Load has priority over shift; otherwise the stage holds.
    assign nextStages[i] = strobe.loadEn  ? parData[i] :
                           strobe.shiftEn ? shiftSrc   : stages[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stages <= '0;
      lastN  <= 1'b1;
    end else begin
      stages <= nextStages;
      lastN  <= ~nextStages[LAST];
    end
  end

  assign qOut  = stages[LAST];
  assign qOutN = lastN;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (stages == '0 && qOutN));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.loadEn |=> stages == $past(parData));

  assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe.shiftEn && !strobe.loadEn) |=>
      stages == {$past(stages[LAST-1:0]), $past(strobe.serBit)});

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!strobe.loadEn && !strobe.shiftEn) |=> $stable(stages));

  assert_complement_R8: assert property (@(posedge clk)
    !rst |-> (qOutN == ~qOut));

endmodule

// File: rtl/gated_shift_reg.sv
module gated_shift_reg
  import psr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clkIn,
  input  logic             clkGate,
  input  logic             loadN,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             qOut,
  output logic             qOutN
);

  // Bundle layout: {clkIn, clkGate, loadN, serIn, parIn}
  localparam int SYNC_W  = WIDTH + 4;
  localparam int LOADN_B = WIDTH + 1;
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << LOADN_B;

  logic [SYNC_W-1:0] pinRaw;
  logic [SYNC_W-1:0] pinSync;
  psrStrobe_t        strobe;

  assign pinRaw = {clkIn, clkGate, loadN, serIn, parIn};

  psr_sync #(
    .WIDTH(SYNC_W),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .din(pinRaw),
    .dout(pinSync)
  );

  psr_ctrl u_ctrl (
    .clk(clk),
    .rst(rst),
    .clkSync(pinSync[WIDTH+3]),
    .gateSync(pinSync[WIDTH+2]),
    .loadNSync(pinSync[LOADN_B]),
    .serSync(pinSync[WIDTH]),
    .strobe(strobe)
  );

  psr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .parData(pinSync[WIDTH-1:0]),
    .qOut(qOut),
    .qOutN(qOutN)
  );

endmodule

// File: tb/gated_shift_reg_bench.sv
`timescale 1ns/1ps
module gated_shift_reg_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pClk = 1'b0, pGate = 1'b0, pLoadN = 1'b1, pSer = 1'b0;
  logic [7:0] pPar = 8'h00;
  logic       qOut, qOutN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gated_shift_reg u_gated_shift_reg (
    .clk(clk), .rst(rst), .clkIn(pClk), .clkGate(pGate), .loadN(pLoadN),
    .serIn(pSer), .parIn(pPar), .qOut(qOut), .qOutN(qOutN)
  );

  // Behavioural reference: pin history queue, newest first, {clk,gate,loadN,ser,par}.
  localparam logic [11:0] PIN_RST = 12'h200;
  logic [11:0] hq[$] = '{PIN_RST, PIN_RST, PIN_RST};
  logic [7:0]  mdl = 8'h00;

  always @(posedge clk) begin
    logic [11:0] cur, prv;
    if (rst) begin
      hq  = '{PIN_RST, PIN_RST, PIN_RST};
      mdl = 8'h00;
    end else begin
      cur = hq[1];
      prv = hq[2];
      if (!cur[9])
        mdl = cur[7:0];
      else if ((cur[11] | cur[10]) && !(prv[11] | prv[10]))
        mdl = {mdl[6:0], cur[8]};
      hq.push_front({pClk, pGate, pLoadN, pSer, pPar});
      void'(hq.pop_back());
    end
  end

  // R10 / R8: cycle-by-cycle compare against the model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (qOut !== mdl[7] || qOutN !== ~mdl[7]) begin
        fails++;
        $display("FAIL R10 model compare: qOut=%b qOutN=%b expected %b/%b",
                 qOut, qOutN, mdl[7], ~mdl[7]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (qOut !== exp || qOutN !== ~exp) begin
      fails++;
      $display("FAIL %s: qOut=%b qOutN=%b expected %b/%b", tag, qOut, qOutN, exp, ~exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic expSeq [5];
    expSeq = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    tick(4);
    chk("R1 reset state", 1'b0);
    rst = 1'b0;
    tick(2);
    chk("R1 after release", 1'b0);

    // R2: load 0xB2, bit 7 -> qOut
    pLoadN = 1'b0; pPar = 8'hB2;
    tick(3);
    chk("R2 load B2", 1'b1);

    // R3: load 0x4D while clocks and serial input toggle
    pPar = 8'h4D;
    for (int i = 0; i < 6; i++) begin
      pClk = ~pClk; pGate = ~pGate; pSer = ~pSer;
      tick(1);
    end
    pClk = 1'b1; pGate = 1'b0;
    tick(3);
    chk("R3 load ignores clocks", 1'b0);

    // R9: release load with the clock already high: no shift
    pLoadN = 1'b1;
    tick(4);
    chk("R9 edge during load dropped", 1'b0);
    pClk = 1'b0;
    tick(3);
    chk("R9 falling clock no shift", 1'b0);

    // R4: shift 1 via clkIn, H <= D[6]=1
    pSer = 1'b1; pClk = 1'b1;
    tick(3);
    chk("R4 clkIn shift", 1'b1);
    pClk = 1'b0;
    tick(3);

    // R5: shift 2 via clkGate, H <= D[5]=0
    pGate = 1'b1;
    tick(3);
    chk("R5 clkGate shift", 1'b0);
    pGate = 1'b0;
    tick(3);

    // R4 shift 3 (H <= D[4]=0), then R6 gate rise while clock high
    pClk = 1'b1;
    tick(3);
    chk("R4 clkIn shift 3", 1'b0);
    pGate = 1'b1;
    tick(3);
    chk("R6 gate rise with clock high", 1'b0);
    pGate = 1'b0;
    tick(1);
    pClk = 1'b0;
    tick(3);
    chk("R6 falling inputs no shift", 1'b0);

    // R7: hold while serial input toggles
    for (int i = 0; i < 10; i++) begin
      pSer = ~pSer;
      tick(1);
    end
    chk("R7 hold", 1'b0);
    pSer = 1'b1;
    tick(1);

    // R4/R5: shifts 4..8, alternating clock inputs
    for (int k = 0; k < 5; k++) begin
      if (k % 2 == 0) pClk = 1'b1; else pGate = 1'b1;
      tick(3);
      chk(k % 2 == 0 ? "R4 shift sequence" : "R5 shift sequence", expSeq[k]);
      pClk = 1'b0; pGate = 1'b0;
      tick(3);
    end

    // R10: latency of a load, old value at 2 edges, new at 3
    pLoadN = 1'b0; pPar = 8'h00;
    tick(2);
    chk("R10 not yet visible", 1'b1);
    tick(1);
    chk("R10 visible at third edge", 1'b0);
    pLoadN = 1'b1;
    tick(3);
    chk("R8 complement after load", 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule